// File: doc/BRIEF.md
# Channel Scan Sequencer

This block decides which of eight input channels the conversion engine works on next, and when. Software programs a mode word, a channel enable mask and a starting index through a small parallel register port fed by the serial front end. Writing the starting index launches work: the sequencer hands a channel number and a one-cycle start pulse to the conversion controller, waits for that controller's done strobe, then finds the next enabled channel by a circular search upward from the current one, wrapping from the top channel back to channel 0.

Three scan modes exist. In step mode each command converts one channel and the pointer moves to the next enabled channel. In single-pass mode every enabled channel is converted once, starting at the chosen channel, and the scan stops when the search would return to where it began. In continuous mode the pass repeats until software rewrites the mode word or the mask. A mode bit can dedicate channel 0 to the reference input, which removes it from every search. A status word reports busy, done and the pointer; an interrupt request, gated by a mode bit, follows the done flag and is meant to drive an open-drain pad low while active.

Top module: `scan_sequencer`

## Requirements
- R1: After a synchronous active-low reset the mode word, mask, pointer, busy and done are all zero, `conv_start` is low and `irq_drive` is low.
- R2: A write to address 2 starts a scan at the first enabled channel at or above index `reg_wdata[2:0]`; `conv_start` is high for exactly one cycle, in the cycle after the write edge, with `conv_chan` holding that channel. A start written while busy abandons the current scan and restarts.
- R3: The search for a channel skips every channel whose mask bit is 0 and wraps from channel 7 to channel 0.
- R4: Mode field `reg_wdata[1:0]` = 00 (step): each launch converts one channel, then busy clears, done sets and the pointer moves to the next enabled channel; a write to address 3 while idle converts the channel at the pointer (searched inclusively).
- R5: Mode field 01 (single pass): after each done strobe the next enabled channel is launched, until the next one equals the first channel of the scan; then busy clears and done sets.
- R6: Mode field 10 or 11 (continuous): the pass repeats without end, done setting each time a pass completes; a write to address 0 or 1 stops the scan so that busy is 0 after that edge and no further `conv_start` appears.
- R7: Mode bit 2 (`ref_ext` output) set removes channel 0 from the enabled set for every search.
- R8: If the effective enabled set is empty, a start write or step command launches nothing and busy stays 0.
- R9: Done is cleared by a read of address 3 or a write of address 2; `irq_drive` is high exactly when done is set and mode bit 3 is 1.
- R10: A `conv_done` strobe while no conversion is awaited changes nothing.
- R11: `reg_rdata` is combinational on `reg_addr`: address 0 returns mode bits [3:0], address 1 the mask, address 3 the status with bit 0 busy, bit 1 done and bits [4:2] the pointer; other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears done when reading status) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| conv_start | output | 1 | One-cycle launch pulse to the conversion controller |
| conv_chan | output | 3 | Channel to convert |
| conv_done | input | 1 | Conversion finished strobe |
| ref_ext | output | 1 | Channel 0 used as reference |
| irq_drive | output | 1 | Interrupt active: pull the open-drain line low |

## Verification
The hardest situations to reach are the ones where a register write lands in the middle of a conversion: a mask or mode rewrite that must abort a continuous scan while the controller's done strobe is still outstanding, and a fresh start written while busy so that a stale done arrives for the new scan. The stimulus drives the controller's handshake from a fixed-latency emulator and places those writes a few cycles after a launch, while a stray done strobe is injected by hand during idle, and every cycle is compared against a behavioural model.

// File: rtl/scan_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and register map of the channel scan sequencer.
package scan_seq_pkg;
    typedef enum logic [1:0] {
        SM_STEP = 2'd0,
        SM_ONCE = 2'd1,
        SM_CONT = 2'd2
    } scan_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_state_e;

    localparam int unsigned ADDR_MODE  = 0;
    localparam int unsigned ADDR_MASK  = 1;
    localparam int unsigned ADDR_START = 2;
    localparam int unsigned ADDR_STAT  = 3;

    localparam int unsigned MODE_EXT_BIT = 2;
    localparam int unsigned MODE_IEN_BIT = 3;

    // Map the two-bit mode field to a scan mode; both upper codes mean continuous.
    function automatic scan_mode_e decode_mode(input logic [1:0] f);
        if (f[1])      return SM_CONT;
        else if (f[0]) return SM_ONCE;
        else           return SM_STEP;
    endfunction
endpackage

// File: rtl/scan_next.sv
`timescale 1ns/1ps
// Circular search: returns the first set mask bit at or above 'base',
// wrapping past the top channel. Assumes N_CH >= 2.
module scan_next #(
    parameter int N_CH = 8,
    localparam int CW = $clog2(N_CH)
) (
    input  logic [N_CH-1:0] mask,
    input  logic [CW-1:0]   base,
    output logic            found,
    output logic [CW-1:0]   idx
);
    // Walk from farthest to nearest so the nearest hit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N_CH - 1; k >= 0; k--) begin
            if (mask[(int'(base) + k) % N_CH]) begin
                found = 1'b1;
                idx   = CW'((int'(base) + k) % N_CH);
            end
        end
    end
endmodule

// File: rtl/scan_regs.sv
`timescale 1ns/1ps
// Mode and mask registers plus the combinational read-back mux.
// Assumes N_CH <= DW and that the status word fits in DW bits.
module scan_regs
    import scan_seq_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int DW   = 8,
    parameter int AW   = 2,
    localparam int CW  = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            busy,
    input  logic            done,
    input  logic [CW-1:0]   ptr,
    output scan_mode_e      mode,
    output logic            ext_ref,
    output logic            irq_en,
    output logic [N_CH-1:0] eff_mask,
    output logic [DW-1:0]   rdata
);
    localparam logic [AW-1:0] A_MODE = AW'(ADDR_MODE);
    localparam logic [AW-1:0] A_MASK = AW'(ADDR_MASK);
    localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);

    logic [1:0]      mode_q;
    logic [N_CH-1:0] mask_q;

    // Capture register writes from the parallel port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            ext_ref <= 1'b0;
            irq_en  <= 1'b0;
            mask_q  <= '0;
        end else if (wr && addr == A_MODE) begin
            mode_q  <= wdata[1:0];
            ext_ref <= wdata[MODE_EXT_BIT];
            irq_en  <= wdata[MODE_IEN_BIT];
        end else if (wr && addr == A_MASK) begin
            mask_q  <= wdata[N_CH-1:0];
        end
    end

    assign mode = decode_mode(mode_q);

    // Drop channel 0 from the search when it serves as the reference.
    always_comb begin
        eff_mask = mask_q;
        if (ext_ref) eff_mask[0] = 1'b0;
    end

    // Read-back mux.
    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE: begin
                rdata[1:0]          = mode_q;
                rdata[MODE_EXT_BIT] = ext_ref;
                rdata[MODE_IEN_BIT] = irq_en;
            end
            A_MASK: rdata[N_CH-1:0] = mask_q;
            A_STAT: begin
                rdata[0]      = busy;
                rdata[1]      = done;
                rdata[2 +: CW] = ptr;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/scan_fsm.sv
`timescale 1ns/1ps
// Launch/wait sequencer: owns the channel pointer, the first channel of the
// current scan and the done flag. Assumes the conversion controller raises
// conv_done once per launch; strobes outside the wait state are ignored.
module scan_fsm
    import scan_seq_pkg::*;
#(
    parameter int N_CH = 8,
    localparam int CW  = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_wr,
    input  logic            step_wr,
    input  logic            abort,
    input  logic            stat_rd,
    input  logic [CW-1:0]   start_idx,
    input  scan_mode_e      mode,
    input  logic [N_CH-1:0] eff_mask,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CW-1:0]   conv_chan,
    output logic            busy,
    output logic            done,
    output logic [CW-1:0]   ptr
);
    seq_state_e    state_q;
    logic [CW-1:0] first_q;
    logic [CW-1:0] seek_base, adv_base, seek_idx, adv_idx;
    logic          seek_found, adv_found, step_ok, set_done;

    assign seek_base = start_wr ? start_idx : ptr;
    assign adv_base  = (ptr == CW'(N_CH - 1)) ? '0 : ptr + 1'b1;

    scan_next #(.N_CH(N_CH)) u_seek (
        .mask(eff_mask), .base(seek_base), .found(seek_found), .idx(seek_idx));
    scan_next #(.N_CH(N_CH)) u_adv (
        .mask(eff_mask), .base(adv_base), .found(adv_found), .idx(adv_idx));

    assign step_ok  = step_wr && state_q == ST_IDLE && mode == SM_STEP;
    assign set_done = !abort && !start_wr && !step_ok && state_q == ST_WAIT
                      && conv_done && (mode == SM_STEP || adv_idx == first_q);

    // Sequence state, pointer and scan origin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr     <= '0;
            first_q <= '0;
        end else if (abort) begin
            state_q <= ST_IDLE;
        end else if (start_wr || step_ok) begin
            if (seek_found) begin
                state_q <= ST_LAUNCH;
                ptr     <= seek_idx;
                first_q <= seek_idx;
            end else begin
                state_q <= ST_IDLE;
            end
        end else begin
            case (state_q)
                ST_LAUNCH: state_q <= ST_WAIT;
                ST_WAIT: if (conv_done && adv_found) begin
                    ptr <= adv_idx;
                    case (mode)
                        SM_STEP: state_q <= ST_IDLE;
                        SM_ONCE: state_q <= (adv_idx == first_q) ? ST_IDLE : ST_LAUNCH;
                        default: state_q <= ST_LAUNCH;
                    endcase
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Done flag: set on completion, cleared by status read or new start.
    always_ff @(posedge clk) begin
        if (!rst_n)                   done <= 1'b0;
        else if (set_done)            done <= 1'b1;
        else if (start_wr || stat_rd) done <= 1'b0;
    end

    assign conv_start = (state_q == ST_LAUNCH);
    assign conv_chan  = ptr;
    assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/scan_sequencer.sv
`timescale 1ns/1ps
// Top of the channel scan sequencer: register port decode, register file
// and launch sequencer. irq_drive high means the pad should pull low.
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int DW   = 8,
    parameter int AW   = 2,
    localparam int CW  = $clog2(N_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          conv_start,
    output logic [CW-1:0] conv_chan,
    input  logic          conv_done,
    output logic          ref_ext,
    output logic          irq_drive
);
    scan_mode_e      mode;
    logic            irq_en, busy, done;
    logic [N_CH-1:0] eff_mask;
    logic [CW-1:0]   ptr;
    logic            start_wr, step_wr, abort, stat_rd;

    // Decode port strobes into sequencer commands.
    assign start_wr = reg_wr && reg_addr == AW'(ADDR_START);
    assign step_wr  = reg_wr && reg_addr == AW'(ADDR_STAT);
    assign abort    = reg_wr && (reg_addr == AW'(ADDR_MODE) || reg_addr == AW'(ADDR_MASK));
    assign stat_rd  = reg_rd && reg_addr == AW'(ADDR_STAT);

    scan_regs #(.N_CH(N_CH), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .done(done), .ptr(ptr), .mode(mode), .ext_ref(ref_ext),
        .irq_en(irq_en), .eff_mask(eff_mask), .rdata(reg_rdata));

    scan_fsm #(.N_CH(N_CH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .step_wr(step_wr),
        .abort(abort), .stat_rd(stat_rd), .start_idx(reg_wdata[CW-1:0]),
        .mode(mode), .eff_mask(eff_mask), .conv_done(conv_done),
        .conv_start(conv_start), .conv_chan(conv_chan), .busy(busy),
        .done(done), .ptr(ptr));

    assign irq_drive = done && irq_en;
endmodule

// File: rtl/scan_sequencer_checker.sv
`timescale 1ns/1ps
// Protocol checks on the scan sequencer, attached by bind.
module scan_sequencer_checker #(
    parameter int N_CH = 8,
    parameter int AW   = 2,
    localparam int CW  = $clog2(N_CH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic            conv_start,
    input logic [CW-1:0]   conv_chan,
    input logic [N_CH-1:0] eff_mask,
    input logic            ext_ref,
    input logic            busy,
    input logic            irq_drive
);
    a_r2_start_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !reg_wr) |=> !conv_start);

    a_r3_chan_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> eff_mask[conv_chan]);

    a_r7_ref_not_converted: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && ext_ref) |-> conv_chan != '0);

    a_r6_reconfig_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == AW'(0) || reg_addr == AW'(1))) |=> !busy);

    a_r9_start_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(2)) |=> !irq_drive);

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !reg_wr) |=> !busy);
endmodule

bind scan_sequencer scan_sequencer_checker #(.N_CH(N_CH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .conv_start(conv_start), .conv_chan(conv_chan), .eff_mask(eff_mask),
    .ext_ref(ref_ext), .busy(busy), .irq_drive(irq_drive));

// File: tb/scan_sequencer_bench.sv
`timescale 1ns/1ps
// Bench: behavioural model updated every clock, compared on every falling edge.
module scan_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, conv_done = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       conv_start, ref_ext, irq_drive;
    logic [2:0] conv_chan;

    int n_cmp = 0, n_err = 0, done_cnt = 0;
    string cur_req = "R1";
    bit finished = 0;

    // model state: 0 idle, 1 launch, 2 wait
    int m_modef = 0, m_ext = 0, m_ien = 0, m_mask = 0;
    int m_state = 0, m_ptr = 0, m_first = 0, m_done = 0;

    always #2.5 clk = ~clk;

    scan_sequencer u_scan_sequencer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
        .ref_ext(ref_ext), .irq_drive(irq_drive));

    function automatic int find_ch(int msk, int base);
        for (int k = 0; k < 8; k++) begin
            if (((msk >> ((base + k) % 8)) & 1) != 0) return (base + k) % 8;
        end
        return -1;
    endfunction

    task automatic model_edge();
        int eff, cls, f, a;
        bit set;
        a = reg_addr;
        if (!rst_n) begin
            m_modef = 0; m_ext = 0; m_ien = 0; m_mask = 0;
            m_state = 0; m_ptr = 0; m_first = 0; m_done = 0;
            return;
        end
        eff = m_ext ? (m_mask & 8'hFE) : m_mask;
        cls = (m_modef >= 2) ? 2 : m_modef;
        set = 0;
        if (reg_wr && (a == 0 || a == 1)) m_state = 0;
        else if (reg_wr && (a == 2 || (a == 3 && m_state == 0 && cls == 0))) begin
            f = find_ch(eff, (a == 2) ? int'(reg_wdata[2:0]) : m_ptr);
            if (f >= 0) begin m_state = 1; m_ptr = f; m_first = f; end
            else m_state = 0;
        end else if (m_state == 1) m_state = 2;
        else if (m_state == 2 && conv_done) begin
            f = find_ch(eff, (m_ptr + 1) % 8);
            m_ptr = f;
            if (cls == 0) begin m_state = 0; set = 1; end
            else if (f == m_first) begin set = 1; if (cls == 1) m_state = 0; else m_state = 1; end
            else m_state = 1;
        end
        if (set) m_done = 1;
        else if ((reg_wr && a == 2) || (reg_rd && a == 3)) m_done = 0;
        if (reg_wr && a == 0) begin
            m_modef = reg_wdata[1:0]; m_ext = reg_wdata[2]; m_ien = reg_wdata[3];
        end else if (reg_wr && a == 1) m_mask = reg_wdata;
    endtask

    task automatic check(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        int er;
        case (reg_addr)
            2'd0: er = m_modef | (m_ext << 2) | (m_ien << 3);
            2'd1: er = m_mask;
            2'd3: er = (m_state != 0 ? 1 : 0) | (m_done << 1) | (m_ptr << 2);
            default: er = 0;
        endcase
        check("conv_start", conv_start, m_state == 1);
        if (m_state == 1) check("conv_chan", conv_chan, m_ptr);
        check("irq_drive", irq_drive, m_done & m_ien);
        check("ref_ext", ref_ext, m_ext);
        check("reg_rdata", reg_rdata, er);
    endtask

    // One clock: model at the rising edge, compare and emulate the controller at the falling edge.
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        conv_done = 1'b0;
        if (conv_start) done_cnt = 2;
        else if (done_cnt > 0) begin
            done_cnt--;
            if (done_cnt == 0) conv_done = 1'b1;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
        tick();
        reg_wr = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic rd(int a);
        reg_rd = 1'b1; reg_addr = 2'(a);
        tick();
        reg_rd = 1'b0;
    endtask

    initial begin
        cur_req = "R1";                     // reset state
        idle(3);
        rst_n = 1'b1;
        reg_addr = 2'd0; tick();
        reg_addr = 2'd1; tick();
        reg_addr = 2'd3; tick();

        cur_req = "R11";                    // readback of mode and mask
        wr(0, 8'h09); wr(1, 8'hA6);
        rd(0); rd(1); reg_addr = 2'd3;

        cur_req = "R5";                     // single pass 5,7,1,2
        wr(2, 3); idle(22);
        cur_req = "R9";                     // status read clears done and irq
        rd(3); idle(2);

        cur_req = "R3";                     // wrap from 7 through 1,2,5
        wr(2, 7); idle(22);
        cur_req = "R2";                     // start on an enabled index; start clears done
        wr(2, 2); idle(5); wr(2, 2); idle(20);

        cur_req = "R6";                     // continuous, then abort by mask write
        wr(0, 8'h02); wr(1, 8'h81); wr(2, 7); idle(25);
        wr(1, 8'h81); idle(6);
        wr(2, 0); idle(7); wr(0, 8'h03); idle(6);

        cur_req = "R4";                     // step mode 2 -> 5 -> 2
        wr(0, 8'h08); wr(1, 8'h24); wr(2, 0); idle(6);
        wr(3, 0); idle(6); rd(3); wr(3, 0); idle(6);

        cur_req = "R7";                     // channel 0 excluded
        wr(0, 8'h05); wr(1, 8'h03); wr(2, 0); idle(10);

        cur_req = "R8";                     // empty effective mask
        wr(1, 8'h01); wr(2, 0); idle(4);
        wr(0, 8'h00); wr(1, 8'h00); wr(3, 0); idle(4);

        cur_req = "R10";                    // stray done while idle
        conv_done = 1'b1; tick(); idle(3);

        cur_req = "R2";                     // restart while busy
        wr(0, 8'h0A); wr(1, 8'hFF); wr(2, 4); idle(3); wr(2, 0); idle(12);
        wr(0, 8'h00); idle(4);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_err++;
            $display("FAIL %s watchdog: actual 1 expected 0", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end
endmodule